// File: doc/BRIEF.md
# Configurable Output Macrocell

This block is the output stage of one cell in a programmable-logic array. It receives product terms that the AND array has already formed. It ORs its own native terms together with any borrowed neighbour terms that have been granted to it. A polarity bit then optionally inverts that sum. The block then presents either the combinational result or the state of a storage element on its pin output. The same value also goes back toward the AND array on a feedback output.

The storage element can act as a D, T, JK or SR flip-flop. The clock is one of two sources: a product term or a dedicated external clock line. Both sources are sampled by the system clock, and a low-to-high change of the chosen source counts as the active edge. Active-high preset and clear terms override the stored value, and they reach the pin in the same cycle without waiting for a clock. All mode settings, including the grant mask for borrowed terms, are captured while reset is held and stay fixed afterwards.

Top module: `mcell_top`

## Requirements
- R1: In combinational mode (`cfg_registered_i`=0), `pin_o` equals (OR of `native_pt_i`) OR (OR of `borrow_pt_i & cfg_grant_i`), XORed with `cfg_invert_i`, within the same cycle.
- R2: A borrowed term whose grant bit is 0 has no effect on the sum.
- R3: `fb_o` always equals `pin_o`.
- R4: With kind code 2'b00 (D), an active clock edge loads the polarity-adjusted sum into the flip-flop.
- R5: With kind code 2'b01 (T), an active edge inverts the state when the sum is 1 and keeps it when the sum is 0.
- R6: With kind code 2'b10 (JK), J is the sum and K is the OR of `aux_pt_i`. On an edge, J=0,K=0 holds, J=1,K=0 sets, J=0,K=1 clears, and J=1,K=1 toggles.
- R7: With kind code 2'b11 (SR), S is the sum and R is the OR of `aux_pt_i`. On an edge, S=1,R=0 sets, S=0,R=1 clears, and both 0 or both 1 hold.
- R8: `cfg_ext_clk_i`=1 selects `ext_clk_i` and 0 selects `pt_clk_i`. The state changes only at the system clock edge where the selected source is sampled high after being sampled low. The unselected source and a held-high level have no effect.
- R9: In registered mode, clear (the OR of the two `clear_pt_i` bits) forces `pin_o` to 0 and `preset_pt_i` forces it to 1 in the same cycle, with no clock edge needed. Clear wins over preset, and the forced value stays stored after both are released.
- R10: Configuration inputs are captured only while `rst_ni` is low. Later changes do not affect behaviour.
- R11: After reset the stored state is 0, so registered mode shows `pin_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low reset; configuration captured while low |
| cfg_kind_i | input | 2 | Flip-flop kind: 00 D, 01 T, 10 JK, 11 SR |
| cfg_ext_clk_i | input | 1 | 1 selects external clock, 0 selects product-term clock |
| cfg_invert_i | input | 1 | Polarity XOR on the sum |
| cfg_registered_i | input | 1 | 1 routes stored state to the pin, 0 routes the sum |
| cfg_grant_i | input | N_BORROW | Per-term enable for borrowed terms |
| ext_clk_i | input | 1 | Dedicated external clock line |
| pt_clk_i | input | 1 | Product-term clock |
| native_pt_i | input | N_NATIVE | Native product terms |
| borrow_pt_i | input | N_BORROW | Borrowed product terms |
| aux_pt_i | input | N_AUX | Second term group (K or R) |
| preset_pt_i | input | 1 | Active-high preset term |
| clear_pt_i | input | 2 | Two active-high clear terms, ORed |
| pin_o | output | 1 | Pin drive value |
| fb_o | output | 1 | Feedback to the AND array |

## Verification
The bench uses the defaults: 3 native terms, 6 borrowed terms and 2 auxiliary terms. With these sizes every native and borrowed term pattern can be swept under three grant masks and both polarities. Every flip-flop kind is run from both starting states against every combination of the two term groups, under both polarities. Directed sequences cover clock-source selection, level-versus-edge behaviour, preset and clear priority, and configuration changes after reset.

// File: rtl/mcell_pkg.sv
package mcell_pkg;

    typedef enum logic [1:0] {
        FF_D  = 2'b00,
        FF_T  = 2'b01,
        FF_JK = 2'b10,
        FF_SR = 2'b11
    } ff_kind_e;

    typedef struct packed {
        ff_kind_e kind;
        logic     ext_clk_sel;
        logic     invert;
        logic     registered;
    } mcell_mode_t;

endpackage

// File: rtl/mcell_sum.sv
module mcell_sum #(
    parameter int N_NATIVE = 3,
    parameter int N_BORROW = 6
) (
    input  logic [N_NATIVE-1:0] native_i,
    input  logic [N_BORROW-1:0] borrow_i,
    input  logic [N_BORROW-1:0] grant_i,
    input  logic                invert_i,
    output logic                sum_o
);
    localparam int N_TERMS = N_NATIVE + N_BORROW;

    logic [N_TERMS-1:0] terms;

    generate
        for (genvar g = 0; g < N_NATIVE; g++) begin : g_native
            assign terms[g] = native_i[g];
        end
        for (genvar g = 0; g < N_BORROW; g++) begin : g_borrow
            assign terms[N_NATIVE+g] = borrow_i[g] & grant_i[g];
        end
    endgenerate

    always_comb begin
        sum_o = (|terms) ^ invert_i;
    end
endmodule

// File: rtl/mcell_clkedge.sv
module mcell_clkedge (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic sel_ext_i,
    input  logic ext_clk_i,
    input  logic pt_clk_i,
    output logic edge_o
);
    typedef struct packed {
        logic prev;
    } edge_state_t;

    edge_state_t st_d, st_q;
    logic        chosen;

    always_comb begin
        chosen  = sel_ext_i ? ext_clk_i : pt_clk_i;
        edge_o  = chosen & ~st_q.prev;
        st_d    = st_q;
        st_d.prev = chosen;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.prev <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/mcell_store.sv
module mcell_store
    import mcell_pkg::*;
(
    input  logic     clk_i,
    input  logic     rst_ni,
    input  ff_kind_e kind_i,
    input  logic     edge_i,
    input  logic     a_i,
    input  logic     b_i,
    input  logic     preset_i,
    input  logic     clear_i,
    output logic     q_o
);
    typedef struct packed {
        logic bit_v;
    } store_state_t;

    store_state_t st_d, st_q;
    logic         nxt;

    always_comb begin
        unique case (kind_i)
            FF_D:    nxt = a_i;
            FF_T:    nxt = st_q.bit_v ^ a_i;
            FF_JK: begin
                unique case ({a_i, b_i})
                    2'b00:   nxt = st_q.bit_v;
                    2'b10:   nxt = 1'b1;
                    2'b01:   nxt = 1'b0;
                    default: nxt = ~st_q.bit_v;
                endcase
            end
            default: begin
                unique case ({a_i, b_i})
                    2'b10:   nxt = 1'b1;
                    2'b01:   nxt = 1'b0;
                    default: nxt = st_q.bit_v;
                endcase
            end
        endcase

        st_d = st_q;
        if (clear_i) begin
            st_d.bit_v = 1'b0;
        end else if (preset_i) begin
            st_d.bit_v = 1'b1;
        end else if (edge_i) begin
            st_d.bit_v = nxt;
        end

        if (clear_i) begin
            q_o = 1'b0;
        end else if (preset_i) begin
            q_o = 1'b1;
        end else begin
            q_o = st_q.bit_v;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.bit_v <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/mcell_top.sv
module mcell_top
    import mcell_pkg::*;
#(
    parameter int N_NATIVE = 3,
    parameter int N_BORROW = 6,
    parameter int N_AUX    = 2
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic [1:0]          cfg_kind_i,
    input  logic                cfg_ext_clk_i,
    input  logic                cfg_invert_i,
    input  logic                cfg_registered_i,
    input  logic [N_BORROW-1:0] cfg_grant_i,
    input  logic                ext_clk_i,
    input  logic                pt_clk_i,
    input  logic [N_NATIVE-1:0] native_pt_i,
    input  logic [N_BORROW-1:0] borrow_pt_i,
    input  logic [N_AUX-1:0]    aux_pt_i,
    input  logic                preset_pt_i,
    input  logic [1:0]          clear_pt_i,
    output logic                pin_o,
    output logic                fb_o
);
    typedef struct packed {
        mcell_mode_t         mode;
        logic [N_BORROW-1:0] grant;
    } cfg_state_t;

    cfg_state_t  cfg_d, cfg_q;
    mcell_mode_t mode_q;
    logic        sum_pol;
    logic        aux_any;
    logic        clear_any;
    logic        clk_edge;
    logic        reg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (!rst_ni) begin
            cfg_d.mode.kind        = ff_kind_e'(cfg_kind_i);
            cfg_d.mode.ext_clk_sel = cfg_ext_clk_i;
            cfg_d.mode.invert      = cfg_invert_i;
            cfg_d.mode.registered  = cfg_registered_i;
            cfg_d.grant            = cfg_grant_i;
        end
    end

    always_ff @(posedge clk_i) begin
        cfg_q <= cfg_d;
    end

    assign mode_q    = cfg_q.mode;
    assign aux_any   = |aux_pt_i;
    assign clear_any = |clear_pt_i;

    mcell_sum #(
        .N_NATIVE(N_NATIVE),
        .N_BORROW(N_BORROW)
    ) u_sum (
        .native_i (native_pt_i),
        .borrow_i (borrow_pt_i),
        .grant_i  (cfg_q.grant),
        .invert_i (mode_q.invert),
        .sum_o    (sum_pol)
    );

    mcell_clkedge u_edge (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .sel_ext_i (mode_q.ext_clk_sel),
        .ext_clk_i (ext_clk_i),
        .pt_clk_i  (pt_clk_i),
        .edge_o    (clk_edge)
    );

    mcell_store u_store (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .kind_i   (mode_q.kind),
        .edge_i   (clk_edge),
        .a_i      (sum_pol),
        .b_i      (aux_any),
        .preset_i (preset_pt_i),
        .clear_i  (clear_any),
        .q_o      (reg_q)
    );

    always_comb begin
        pin_o = mode_q.registered ? reg_q : sum_pol;
        fb_o  = pin_o;
    end
endmodule

// File: rtl/mcell_chk.sv
module mcell_chk
    import mcell_pkg::*;
(
    input logic        clk_i,
    input logic        rst_ni,
    input mcell_mode_t mode_i,
    input logic        edge_i,
    input logic        sum_i,
    input logic        aux_i,
    input logic        preset_i,
    input logic        clear_i,
    input logic        pin_i
);
    assert_comb_path_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !mode_i.registered |-> pin_i == sum_i);

    assert_clear_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_i.registered && clear_i) |-> !pin_i);

    assert_preset_sets_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_i.registered && preset_i && !clear_i) |-> pin_i);

    assert_hold_no_edge_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_i.registered && !edge_i && !preset_i && !clear_i) ##1 (!preset_i && !clear_i)
        |-> pin_i == $past(pin_i));

    assert_d_load_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_i.registered && mode_i.kind == FF_D && edge_i && !preset_i && !clear_i)
        ##1 (!preset_i && !clear_i) |-> pin_i == $past(sum_i));

    assert_t_toggle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_i.registered && mode_i.kind == FF_T && edge_i && sum_i && !preset_i && !clear_i)
        ##1 (!preset_i && !clear_i) |-> pin_i != $past(pin_i));

    assert_sr_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_i.registered && mode_i.kind == FF_SR && edge_i && sum_i && aux_i
         && !preset_i && !clear_i) ##1 (!preset_i && !clear_i) |-> pin_i == $past(pin_i));

    assert_cfg_frozen_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(rst_ni) |-> $stable(mode_i));
endmodule

bind mcell_top mcell_chk u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .mode_i   (mode_q),
    .edge_i   (clk_edge),
    .sum_i    (sum_pol),
    .aux_i    (aux_any),
    .preset_i (preset_pt_i),
    .clear_i  (clear_any),
    .pin_i    (pin_o)
);

// File: tb/tb_mcell_top.sv
module tb_mcell_top;
    localparam int CLK_PERIOD = 10;
    localparam int NN = 3;
    localparam int NB = 6;
    localparam int NA = 2;

    logic          clk_i = 1'b0;
    logic          rst_ni = 1'b0;
    logic [1:0]    cfg_kind_i = 2'b00;
    logic          cfg_ext_clk_i = 1'b1;
    logic          cfg_invert_i = 1'b0;
    logic          cfg_registered_i = 1'b0;
    logic [NB-1:0] cfg_grant_i = '0;
    logic          ext_clk_i = 1'b0;
    logic          pt_clk_i = 1'b0;
    logic [NN-1:0] native_pt_i = '0;
    logic [NB-1:0] borrow_pt_i = '0;
    logic [NA-1:0] aux_pt_i = '0;
    logic          preset_pt_i = 1'b0;
    logic [1:0]    clear_pt_i = 2'b00;
    logic          pin_o;
    logic          fb_o;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk_i = ~clk_i;

    mcell_top #(.N_NATIVE(NN), .N_BORROW(NB), .N_AUX(NA)) dut (
        .clk_i, .rst_ni, .cfg_kind_i, .cfg_ext_clk_i, .cfg_invert_i,
        .cfg_registered_i, .cfg_grant_i, .ext_clk_i, .pt_clk_i,
        .native_pt_i, .borrow_pt_i, .aux_pt_i, .preset_pt_i, .clear_pt_i,
        .pin_o, .fb_o
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_reset(input logic [1:0] kind, input logic ext, input logic inv,
                            input logic regd, input logic [NB-1:0] grant);
        @(negedge clk_i);
        rst_ni = 1'b0;
        cfg_kind_i = kind; cfg_ext_clk_i = ext; cfg_invert_i = inv;
        cfg_registered_i = regd; cfg_grant_i = grant;
        ext_clk_i = 0; pt_clk_i = 0; native_pt_i = '0; borrow_pt_i = '0;
        aux_pt_i = '0; preset_pt_i = 0; clear_pt_i = 2'b00;
        repeat (2) @(posedge clk_i);
        @(negedge clk_i);
        rst_ni = 1'b1;
        @(negedge clk_i);
    endtask

    // one high sample then one low sample of the chosen clock line
    task automatic pulse(input logic use_ext);
        if (use_ext) ext_clk_i = 1'b1; else pt_clk_i = 1'b1;
        @(negedge clk_i);
        if (use_ext) ext_clk_i = 1'b0; else pt_clk_i = 1'b0;
        @(negedge clk_i);
        #1;
    endtask

    task automatic force_state(input logic v);
        if (v) preset_pt_i = 1'b1; else clear_pt_i = 2'b01;
        @(negedge clk_i);
        preset_pt_i = 1'b0; clear_pt_i = 2'b00;
        @(negedge clk_i);
    endtask

    function automatic logic model_next(input int kind, input logic s, input logic j,
                                        input logic k);
        case (kind)
            0: return j;
            1: return s ^ j;
            2: return (j && k) ? ~s : (j ? 1'b1 : (k ? 1'b0 : s));
            default: return (j && !k) ? 1'b1 : ((!j && k) ? 1'b0 : s);
        endcase
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [NB-1:0] grants [3];
        grants[0] = '0; grants[1] = '1; grants[2] = 6'b010101;

        // R11: reset state in registered mode
        do_reset(2'b00, 1'b1, 1'b0, 1'b1, '0);
        #1;
        check("R11 reset pin", pin_o, 1'b0);
        check("R3 reset fb", fb_o, 1'b0);

        // R1, R2, R3: full combinational sweep
        for (int gi = 0; gi < 3; gi++) begin
            for (int inv = 0; inv < 2; inv++) begin
                do_reset(2'b00, 1'b1, 1'(inv), 1'b0, grants[gi]);
                for (int n = 0; n < 8; n++) begin
                    for (int b = 0; b < 64; b++) begin
                        logic exp;
                        @(negedge clk_i);
                        native_pt_i = 3'(n);
                        borrow_pt_i = 6'(b);
                        #1;
                        exp = ((n != 0) || ((6'(b) & grants[gi]) != 0)) ^ 1'(inv);
                        if (n == 0 && b != 0 && (6'(b) & grants[gi]) == 0)
                            check("R2 ungranted borrow", pin_o, exp);
                        else
                            check("R1 comb sum", pin_o, exp);
                        check("R3 feedback", fb_o, pin_o);
                    end
                end
            end
        end

        // R4-R7: every kind, polarity, start state and term pair
        for (int kind = 0; kind < 4; kind++) begin
            for (int inv = 0; inv < 2; inv++) begin
                for (int s0 = 0; s0 < 2; s0++) begin
                    for (int a = 0; a < 2; a++) begin
                        for (int k = 0; k < 2; k++) begin
                            logic exp;
                            do_reset(2'(kind), 1'b1, 1'(inv), 1'b1, '0);
                            force_state(1'(s0));
                            native_pt_i = a ? 3'b010 : 3'b000;
                            aux_pt_i    = k ? 2'b10 : 2'b00;
                            pulse(1'b1);
                            exp = model_next(kind, 1'(s0), 1'(a) ^ 1'(inv), 1'(k));
                            case (kind)
                                0: check("R4 D load", pin_o, exp);
                                1: check("R5 T toggle", pin_o, exp);
                                2: check("R6 JK", pin_o, exp);
                                default: check("R7 SR", pin_o, exp);
                            endcase
                        end
                    end
                end
            end
        end

        // R8: product-term clock selected, external ignored
        do_reset(2'b00, 1'b0, 1'b0, 1'b1, '0);
        native_pt_i = 3'b001;
        pulse(1'b1);
        check("R8 unselected ext ignored", pin_o, 1'b0);
        pulse(1'b0);
        check("R8 pt clock loads", pin_o, 1'b1);
        // R8: external selected, product-term clock ignored
        do_reset(2'b00, 1'b1, 1'b0, 1'b1, '0);
        native_pt_i = 3'b100;
        pulse(1'b0);
        check("R8 unselected pt ignored", pin_o, 1'b0);
        // R8: level held high loads once only
        ext_clk_i = 1'b1;
        @(negedge clk_i); #1;
        check("R8 edge loads", pin_o, 1'b1);
        native_pt_i = 3'b000;
        repeat (3) @(negedge clk_i);
        #1;
        check("R8 held level no reload", pin_o, 1'b1);
        ext_clk_i = 1'b0;
        @(negedge clk_i);

        // R9: asynchronous preset/clear with priority
        do_reset(2'b00, 1'b1, 1'b0, 1'b1, '0);
        preset_pt_i = 1'b1;
        #1;
        check("R9 preset immediate", pin_o, 1'b1);
        clear_pt_i = 2'b10;
        #1;
        check("R9 clear beats preset", pin_o, 1'b0);
        clear_pt_i = 2'b01;
        #1;
        check("R9 other clear term", pin_o, 1'b0);
        @(negedge clk_i);
        preset_pt_i = 1'b0; clear_pt_i = 2'b00;
        @(negedge clk_i); #1;
        check("R9 cleared value kept", pin_o, 1'b0);
        preset_pt_i = 1'b1;
        @(negedge clk_i);
        preset_pt_i = 1'b0;
        @(negedge clk_i); #1;
        check("R9 preset value kept", pin_o, 1'b1);

        // R10: configuration frozen after reset
        do_reset(2'b00, 1'b1, 1'b0, 1'b0, '0);
        cfg_invert_i = 1'b1; cfg_registered_i = 1'b1; cfg_grant_i = '1;
        @(negedge clk_i);
        native_pt_i = 3'b001;
        #1;
        check("R10 polarity and mode frozen", pin_o, 1'b1);
        @(negedge clk_i);
        native_pt_i = 3'b000; borrow_pt_i = '1;
        #1;
        check("R10 grant frozen", pin_o, 1'b0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule